// File: doc/BRIEF.md
# Single-Pin Counter Sync Controller

This block drives one bidirectional pin. The pin is the clock of an external up-counter. Through a series resistor, the same pin also reads back that counter's most significant bit (MSB). After reset the counter value is unknown. The controller first recovers it by issuing clock-and-read operations on the pin. It then steps the counter to a value that the host requests, and parks the pin so that no current flows through the resistor while the counter holds its value (for example, an LED pattern).

A clock-and-read always produces exactly one rising edge. If the last sample was high, the pin is driven high, then low, then high. If the last sample was low, it is driven low, then high. In both cases the pin is then released and allowed to settle, and the MSB is sampled. The MSB goes from low to high only once per count cycle. A low sample followed by a high sample therefore pins the counter to the first value whose MSB is set. Once the controller is in step, it moves the counter with back-to-back low/high pulses and no reads. Only the single step that crosses into the MSB-high half is read on both sides, which confirms that the counter is still in step. If that read disagrees, the full recovery runs again before the pending request is served.

Top module: `onepin_counter_sync`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pin_oe`, `busy` and `synced` are all 0.
- R2: A request (`req_valid` high) is taken only in a cycle where `busy` is low, and `busy` is high in the following cycle. A request raised while `busy` is high is ignored and does not change the value the counter ends on.
- R3: `busy` stays high from the accepted request until the pin is parked. When it falls, the external counter holds the requested binary value `req_target`.
- R4: Recovery starts with a plain released read and then repeats clock-and-reads. A high-start read follows a high sample and a low-start read follows a low sample. `synced` rises, with `busy` high, the first time a low sample is followed by a high sample. At that moment the counter holds 2^(CNT_W-1).
- R5: Every clock-and-read and every pulse gives the counter exactly one rising edge. A move from a known value c to a target t therefore produces exactly (t - c) mod 2^CNT_W rising edges, wrapping through zero when t < c.
- R6: Every level that is actively driven on the pin is held for at least PHASE_CYC cycles before the pin is driven to the other level.
- R7: When a move crosses from 2^(CNT_W-1)-1 to 2^(CNT_W-1), the controller samples before the step (expecting low) and after it (expecting high). A wrong level drops `synced`, reruns recovery and still finishes on the requested value.
- R8: While `busy` is low, the pin is released (`pin_oe`=0) if `synced` is low. If `synced` is high, the pin is driven (`pin_oe`=1) with `pin_out` equal to the counter's MSB.
- R9: `synced` changes only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_target | input | CNT_W | Requested counter value |
| busy | output | 1 | Request in progress |
| synced | output | 1 | Counter value is known |
| pin_oe | output | 1 | Pin driver enable |
| pin_out | output | 1 | Pin level when driven |
| pin_in | input | 1 | Sampled pin level (counter MSB when released) |

## Verification
The properties check the following on every cycle:
- the request handshake;
- the idle pin policy for both values of `synced`;
- the rule that `synced` moves only while busy and rises only inside a request;
- the minimum hold time of each driven level.

Only the bench's counter model can show the outcome of a request: that recovery lands on the first MSB-high value from every starting value, that each move yields exactly the modular number of rising edges including wrap-around, and that a counter knocked out of step is caught at the MSB crossing and recovered.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;

   // pin operations the engine can run
   typedef enum logic [1:0] {
      OP_LOOK  = 2'd0,   // release, settle, sample
      OP_HI_RD = 2'd1,   // high, low, high, release, settle, sample
      OP_LO_RD = 2'd2,   // low, high, release, settle, sample
      OP_STEP  = 2'd3    // low, high, keep driving
   } pin_op_e;

   typedef enum logic [1:0] {
      E_IDLE   = 2'd0,
      E_DRIVE  = 2'd1,
      E_SETTLE = 2'd2
   } eng_ph_e;

   typedef enum logic [2:0] {
      S_IDLE      = 3'd0,
      S_SYNC_LOOK = 3'd1,
      S_SYNC_RD   = 3'd2,
      S_DECIDE    = 3'd3,
      S_STEP      = 3'd4,
      S_CHK_LOOK  = 3'd5,
      S_CHK_RD    = 3'd6,
      S_PARK      = 3'd7
   } seq_st_e;

endpackage

// File: rtl/pinseq_timer.sv
module pinseq_timer #(
   parameter int TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/pinseq_insync.sv
module pinseq_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q <= {sh_q[STAGES-2:0], d};
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pinseq_engine.sv
module pinseq_engine
   import pinseq_pkg::*;
#(
   parameter int PHASE_CYC   = 2,
   parameter int SETTLE_CYC  = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    go,
   input  pin_op_e op,
   input  logic    park_en,
   input  logic    park_oe,
   input  logic    park_val,
   input  logic    pin_in,
   output logic    done,
   output logic    sample,
   output logic    oe,
   output logic    val
);

   localparam int MAXC = (PHASE_CYC > SETTLE_CYC) ? PHASE_CYC : SETTLE_CYC;
   localparam int TW   = $clog2(MAXC + 1);
   localparam logic [TW-1:0] PH_LOAD = TW'(PHASE_CYC - 1);
   localparam logic [TW-1:0] ST_LOAD = TW'(SETTLE_CYC - 1);

   eng_ph_e    ph_q;
   logic [1:0] idx_q;
   logic [1:0] nd_q;
   logic [2:0] pat_q;
   logic       rd_q;
   logic [1:0] nd_d;
   logic [2:0] pat_d;
   logic       rd_d;
   logic [2:0] idx_nx;
   logic       more_drive;
   logic       tmr_load;
   logic [TW-1:0] tmr_val;
   logic       tmr_zero;
   logic       pin_s;

   // decode: number of drive phases, levels (phase 0 in bit 0), read flag
   always_comb begin
      case (op)
         OP_LOOK:  begin nd_d = 2'd0; pat_d = 3'b000; rd_d = 1'b1; end
         OP_HI_RD: begin nd_d = 2'd3; pat_d = 3'b101; rd_d = 1'b1; end
         OP_LO_RD: begin nd_d = 2'd2; pat_d = 3'b010; rd_d = 1'b1; end
         default:  begin nd_d = 2'd2; pat_d = 3'b010; rd_d = 1'b0; end
      endcase
   end

   assign idx_nx     = {1'b0, idx_q} + 3'd1;
   assign more_drive = (idx_nx < {1'b0, nd_q});

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = ST_LOAD;
      if (ph_q == E_IDLE && go) begin
         tmr_load = 1'b1;
         tmr_val  = (nd_d != 2'd0) ? PH_LOAD : ST_LOAD;
      end else if (ph_q == E_DRIVE && tmr_zero && (more_drive || rd_q)) begin
         tmr_load = 1'b1;
         tmr_val  = more_drive ? PH_LOAD : ST_LOAD;
      end
   end

   pinseq_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   pinseq_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= E_IDLE;
         idx_q  <= '0;
         nd_q   <= '0;
         pat_q  <= '0;
         rd_q   <= 1'b0;
         oe     <= 1'b0;
         val    <= 1'b0;
         done   <= 1'b0;
         sample <= 1'b0;
      end else begin
         done <= 1'b0;
         case (ph_q)
            E_IDLE: begin
               if (go) begin
                  nd_q  <= nd_d;
                  pat_q <= pat_d;
                  rd_q  <= rd_d;
                  idx_q <= '0;
                  if (nd_d != 2'd0) begin
                     oe   <= 1'b1;
                     val  <= pat_d[0];
                     ph_q <= E_DRIVE;
                  end else begin
                     oe   <= 1'b0;
                     ph_q <= E_SETTLE;
                  end
               end else if (park_en) begin
                  oe  <= park_oe;
                  val <= park_val;
               end
            end
            E_DRIVE: begin
               if (tmr_zero) begin
                  if (more_drive) begin
                     idx_q <= idx_nx[1:0];
                     val   <= pat_q[idx_nx[1:0]];
                  end else if (rd_q) begin
                     oe   <= 1'b0;
                     ph_q <= E_SETTLE;
                  end else begin
                     done <= 1'b1;
                     ph_q <= E_IDLE;
                  end
               end
            end
            E_SETTLE: begin
               if (tmr_zero) begin
                  sample <= pin_s;
                  done   <= 1'b1;
                  ph_q   <= E_IDLE;
               end
            end
            default: ph_q <= E_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pinseq_park.sv
module pinseq_park #(
   parameter bit IDLE_DRIVE = 1'b1
) (
   input  logic synced,
   input  logic msb,
   output logic oe,
   output logic val
);

   generate
      if (IDLE_DRIVE) begin : g_follow
         // known counter: hold the pin at the MSB level
         assign oe  = synced;
         assign val = msb & synced;
      end else begin : g_float
         logic unused_in;
         assign unused_in = synced ^ msb;
         assign oe  = 1'b0;
         assign val = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/onepin_counter_sync.sv
module onepin_counter_sync
   import pinseq_pkg::*;
#(
   parameter int CNT_W       = 2,
   parameter int PHASE_CYC   = 2,
   parameter int SETTLE_CYC  = 50,
   parameter int SYNC_STAGES = 2,
   parameter bit CHECK_EN    = 1'b1,
   parameter bit IDLE_DRIVE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] req_target,
   output logic             busy,
   output logic             synced,
   output logic             pin_oe,
   output logic             pin_out,
   input  logic             pin_in
);

   localparam logic [CNT_W-1:0] MSB_FIRST = CNT_W'(1) << (CNT_W - 1);
   localparam logic [CNT_W-1:0] LAST_LOW  = MSB_FIRST - CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("CNT_W must be at least 1");
      end
      if (PHASE_CYC < 1) begin : g_bad_ph
         $error("PHASE_CYC must be at least 1");
      end
      if (SETTLE_CYC < SYNC_STAGES + 2) begin : g_bad_st
         $error("SETTLE_CYC must exceed the input synchroniser depth by 2");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sy
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   seq_st_e          st_q;
   logic [CNT_W-1:0] cur_q;
   logic [CNT_W-1:0] tgt_q;
   logic             prev_q;
   logic             go_q;
   pin_op_e          op_q;
   logic             eng_done;
   logic             eng_sample;
   logic             park_oe;
   logic             park_val;
   logic             park_en;

   assign park_en = (st_q == S_IDLE) || (st_q == S_PARK);

   pinseq_park #(.IDLE_DRIVE(IDLE_DRIVE)) u_park (
      .synced (synced),
      .msb    (cur_q[CNT_W-1]),
      .oe     (park_oe),
      .val    (park_val)
   );

   pinseq_engine #(
      .PHASE_CYC   (PHASE_CYC),
      .SETTLE_CYC  (SETTLE_CYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go_q),
      .op       (op_q),
      .park_en  (park_en),
      .park_oe  (park_oe),
      .park_val (park_val),
      .pin_in   (pin_in),
      .done     (eng_done),
      .sample   (eng_sample),
      .oe       (pin_oe),
      .val      (pin_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cur_q  <= '0;
         tgt_q  <= '0;
         prev_q <= 1'b0;
         go_q   <= 1'b0;
         op_q   <= OP_LOOK;
         busy   <= 1'b0;
         synced <= 1'b0;
      end else begin
         go_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (req_valid) begin
                  tgt_q <= req_target;
                  busy  <= 1'b1;
                  if (synced) begin
                     st_q <= S_DECIDE;
                  end else begin
                     go_q <= 1'b1;
                     op_q <= OP_LOOK;
                     st_q <= S_SYNC_LOOK;
                  end
               end
            end
            S_SYNC_LOOK: begin
               if (eng_done) begin
                  prev_q <= eng_sample;
                  go_q   <= 1'b1;
                  op_q   <= eng_sample ? OP_HI_RD : OP_LO_RD;
                  st_q   <= S_SYNC_RD;
               end
            end
            S_SYNC_RD: begin
               if (eng_done) begin
                  if (!prev_q && eng_sample) begin
                     synced <= 1'b1;
                     cur_q  <= MSB_FIRST;
                     st_q   <= S_DECIDE;
                  end else begin
                     prev_q <= eng_sample;
                     go_q   <= 1'b1;
                     op_q   <= eng_sample ? OP_HI_RD : OP_LO_RD;
                  end
               end
            end
            S_DECIDE: begin
               if (cur_q == tgt_q) begin
                  st_q <= S_PARK;
               end else if (CHECK_EN && cur_q == LAST_LOW) begin
                  go_q <= 1'b1;
                  op_q <= OP_LOOK;
                  st_q <= S_CHK_LOOK;
               end else begin
                  go_q <= 1'b1;
                  op_q <= OP_STEP;
                  st_q <= S_STEP;
               end
            end
            S_STEP: begin
               if (eng_done) begin
                  cur_q <= cur_q + 1'b1;
                  st_q  <= S_DECIDE;
               end
            end
            S_CHK_LOOK: begin
               if (eng_done) begin
                  go_q <= 1'b1;
                  if (eng_sample) begin
                     synced <= 1'b0;
                     op_q   <= OP_LOOK;
                     st_q   <= S_SYNC_LOOK;
                  end else begin
                     op_q <= OP_LO_RD;
                     st_q <= S_CHK_RD;
                  end
               end
            end
            S_CHK_RD: begin
               if (eng_done) begin
                  if (!eng_sample) begin
                     synced <= 1'b0;
                     go_q   <= 1'b1;
                     op_q   <= OP_LOOK;
                     st_q   <= S_SYNC_LOOK;
                  end else begin
                     cur_q <= MSB_FIRST;
                     st_q  <= S_DECIDE;
                  end
               end
            end
            S_PARK: begin
               busy <= 1'b0;
               st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/onepin_counter_sync_chk.sv
module onepin_counter_sync_chk #(
   parameter int PHASE_CYC  = 2,
   parameter bit IDLE_DRIVE = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic synced,
   input logic pin_oe,
   input logic pin_out
);

   localparam int RW = $clog2(PHASE_CYC + 1) + 1;

   logic [1:0]    key_q;
   logic [RW-1:0] run_q;

   // length of the current run of identical pin drive
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q <= 2'b00;
         run_q <= '0;
      end else begin
         key_q <= {pin_oe, pin_out};
         if ({pin_oe, pin_out} == key_q) begin
            if (run_q < RW'(PHASE_CYC)) run_q <= run_q + 1'b1;
         end else begin
            run_q <= RW'(1);
         end
      end
   end

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);

   // R4
   sync_in_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> busy);

   // R6
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe && key_q[1] && ({pin_oe, pin_out} != key_q)) |-> (run_q >= RW'(PHASE_CYC)));

   // R8
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !synced) |-> !pin_oe);

   // R9
   synced_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (busy || $stable(synced)));

   generate
      if (IDLE_DRIVE) begin : g_drv
         // R8
         idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && synced) |-> pin_oe);
      end
   endgenerate

endmodule

bind onepin_counter_sync onepin_counter_sync_chk #(
   .PHASE_CYC  (PHASE_CYC),
   .IDLE_DRIVE (IDLE_DRIVE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .synced    (synced),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out)
);

// File: tb/test_onepin_counter_sync.sv
module test_onepin_counter_sync;

   localparam int W     = 2;
   localparam int PHASE = 2;
   localparam int HALF  = 1 << (W - 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [W-1:0] req_target = '0;
   logic         busy, synced, pin_oe, pin_out;

   int vectors = 0;
   int fails   = 0;

   // external counter model
   logic [W-1:0] raw = '0;
   logic [W-1:0] offs = '0;
   int           edges = 0;
   bit           model_en = 1'b0;
   wire [W-1:0]  cnt_eff = raw + offs;
   wire          pin_net = pin_oe ? pin_out : cnt_eff[W-1];

   always @(posedge pin_net) begin
      if (model_en) begin
         raw   <= raw + 1'b1;
         edges <= edges + 1;
      end
   end

   always #10 clk = ~clk;

   onepin_counter_sync #(
      .CNT_W      (W),
      .PHASE_CYC  (PHASE),
      .SETTLE_CYC (50),
      .SYNC_STAGES(2),
      .CHECK_EN   (1'b1),
      .IDLE_DRIVE (1'b1)
   ) i_onepin_counter_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_target (req_target),
      .busy       (busy),
      .synced     (synced),
      .pin_oe     (pin_oe),
      .pin_out    (pin_out),
      .pin_in     (pin_net)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // observers
   logic syn_q = 1'b0, busy_q = 1'b0;
   logic [1:0] key_q = 2'b00;
   int run_len = 0, min_hold = 1000, drops = 0, idle_moves = 0, rise_bad = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (synced && !syn_q && cnt_eff != W'(HALF)) rise_bad++;
         if (!synced && syn_q) drops++;
         if (!busy && !busy_q && synced != syn_q) idle_moves++;
         if (pin_oe && key_q[1] && {pin_oe, pin_out} != key_q && run_len < min_hold)
            min_hold = run_len;
      end
      run_len = ({pin_oe, pin_out} == key_q) ? run_len + 1 : 1;
      key_q   = {pin_oe, pin_out};
      syn_q   = synced;
      busy_q  = busy;
   end

   task automatic start_from(input logic [W-1:0] s);
      @(negedge clk);
      model_en = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      offs = s - raw;
      // R1: reset state
      chk("R1 oe", int'(pin_oe), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 synced", int'(synced), 0);
      @(negedge clk);
      model_en = 1'b1;
      rst_n    = 1'b1;
      @(negedge clk);
      chk("R1 oe after", int'(pin_oe), 0);
   endtask

   task automatic do_req(input logic [W-1:0] t);
      @(negedge clk);
      req_valid  = 1'b1;
      req_target = t;
      @(negedge clk);
      req_valid = 1'b0;
      // R2: taken at once
      chk("R2 busy", int'(busy), 1);
      while (busy) @(negedge clk);
   endtask

   task automatic check_end(input string tag, input logic [W-1:0] t);
      chk({tag, " count"}, int'(cnt_eff), int'(t));
      chk("R8 drive", int'(pin_oe), 1);
      chk("R8 level", int'(pin_out), int'(t[W-1]));
      chk("R4 synced", int'(synced), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] prev;
      int e0;
      for (int s = 0; s < (1 << W); s++) begin
         start_from(W'(s));
         prev = W'(s + 3);
         do_req(prev);
         check_end("R3 first", prev);
         for (int t = 0; t < (1 << W); t++) begin
            e0 = edges;
            do_req(W'(t));
            check_end("R3 move", W'(t));
            // R5: modular step count, wrap when t < prev
            chk("R5 edges", edges - e0, (t - int'(prev)) & ((1 << W) - 1));
            prev = W'(t);
         end
      end

      // R2: a request during busy is ignored (prev is 3 here)
      e0 = edges;
      @(negedge clk);
      req_valid = 1'b1; req_target = 2'd2;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      req_valid = 1'b1; req_target = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      check_end("R2 ignored", 2'd2);
      chk("R5 edges busy", edges - e0, 3);

      // R7: counter knocked out of step while idle is caught at the crossing
      do_req(2'd1);
      check_end("R3 pre", 2'd1);
      @(negedge clk);
      offs = offs + 1'b1;
      e0 = drops;
      do_req(2'd3);
      check_end("R7 recover", 2'd3);
      chk("R7 resync", drops - e0, 1);

      chk("R4 rise value", rise_bad, 0);
      chk("R6 hold", int'(min_hold >= PHASE), 1);
      chk("R9 idle synced", idle_moves, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule